// File: doc/BRIEF.md
# Dual-Target Two-Wire Slave Controller

This block is a slave on a two-wire serial bus (I2C) that fronts two internal byte-wide targets: a large memory array and a small clock/control register file. The bus lines are brought into the system clock domain through two-flop synchronisers. Start and stop conditions are recognised on the synchronised samples, and the first byte after a start is decoded to pick a target and a direction. For writes, a two-byte word address follows the address byte. It loads a shared internal address counter, and each accepted data byte is then presented on the internal port as a one-cycle write strobe.

Reads come in two forms. A current-address read starts at the shared counter. A random read is a short write that only sets the word address, followed by a repeated start and a read address byte for the same target. The slave drives SDA through an open-drain enable (`sdaOe` high pulls the line low). It withholds the acknowledge in three cases: when the write-enable latch input is low, when a second data byte arrives in a status-register write, and when a random read changes target between its two halves.

Top module: `dual_target_i2c_slave`

## Requirements
- R1: After reset `sdaOe` is 0, `busWr` is 0 and `busAddr` is 0.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. After a stop, the slave returns to idle and acknowledges nothing until the next start.
- R3: The address byte is sent MSB first. Bits 7..4 select the target: 1010 selects memory (`busTgt`=0) and 1101 selects registers (`busTgt`=1). Bits 3..1 must be 111, and bit 0 is 1 for a read. On a full match the slave acknowledges. On any mismatch it leaves SDA released until the next start.
- R4: In a write, the two bytes after the address byte form the word address, high byte first. Both bytes are acknowledged and the word address is loaded into the counter. For the register target, only its low REG_AW bits are kept.
- R5: While `wrEnLatch` is 1, each write data byte is acknowledged and presented as a one-cycle `busWr` with the counter value on `busAddr` and the byte on `busWData`. The counter then advances by one.
- R6: While `wrEnLatch` is 0, a write data byte is not acknowledged and produces no `busWr`. The slave then stays released until the next start.
- R7: In a register write whose word address equals STATUS_ADDR (default 0x3F), the first data byte is accepted. The second data byte is not acknowledged and produces no `busWr`.
- R8: In a read, the slave sends 8 bits MSB first by asserting `sdaOe` for each 0 bit. It releases SDA for the ninth clock. It sends the next byte when the master acknowledges and stops driving when the master does not.
- R9: A current-address read starts at the counter, which is 0 after reset. The counter advances by one for each byte sent.
- R10: If a repeated start follows a word-address write and the read address byte selects the other target, the read address byte is not acknowledged.
- R11: The counter wraps from 2^MEM_AW-1 to 0 on the memory target and from 2^REG_AW-1 to 0 on the register target.
- R12: `sdaOe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen on the pad |
| sdaIn | input | 1 | Bus data line as seen on the pad |
| sdaOe | output | 1 | Open-drain enable; 1 pulls SDA low |
| wrEnLatch | input | 1 | Write-enable latch level from the register file |
| busAddr | output | MEM_AW | Internal address (counter, masked to target width) |
| busTgt | output | 1 | 0 = memory array, 1 = register file |
| busWr | output | 1 | One-cycle write strobe |
| busWData | output | 8 | Write data byte |
| busRdData | input | 8 | Read data for `busAddr`/`busTgt`, combinational |

## Verification
Accepting a write data byte happens in a single cycle: the acknowledge decision, the write strobe and the counter increment all coincide. On the read side, fetching the next byte and advancing the counter also share one cycle. The bench provokes the write case by toggling `wrEnLatch` and by sending a second byte into the status register. For every strobe it compares address, target and data against a queue of expected writes. A read that runs across the wrap boundary of each target shows whether the increment in the fetch cycle lands on the correct next address. The expected SDA enable is compared on every clock while SCL is high.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WR, ST_RD, ST_SKIP
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic bitInc;
    logic loadTx;
    logic txNext;
    logic bitClr;
    logic ackDrive;
    logic sdaRel;
    logic hiLoad;
    logic cntLoad;
    logic cntInc;
    logic wrStb;
    logic tgtReg;
  } ctl_t;

  // observations from datapath to control
  typedef struct packed {
    logic       sclRise;
    logic       sclFall;
    logic       startDet;
    logic       stopDet;
    logic       sdaLvl;
    logic       bitsDone;
    logic [7:0] rxByte;
  } obs_t;

  localparam logic [3:0] PFX_MEM = 4'b1010;
  localparam logic [3:0] PFX_REG = 4'b1101;
  localparam logic [2:0] DEV_SEL = 3'b111;
endpackage

// File: rtl/dts_datapath.sv
module dts_datapath
  import dts_pkg::*;
#(
  parameter int MEM_AW = 16,
  parameter int REG_AW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctl_t              ctl,
  input  logic [7:0]        rdData,
  output obs_t              obs,
  output logic [MEM_AW-1:0] effAddr,
  output logic [7:0]        shiftOut,
  output logic              sdaOe
);
  localparam logic [MEM_AW-1:0] REG_MASK = MEM_AW'((1 << REG_AW) - 1);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] sclPipe, sdaPipe;
  logic sclQ, sdaQ;
  logic sclS, sdaS;
  logic [7:0] shiftReg;
  logic [3:0] bitCnt;
  logic [7:0] addrHi;
  logic [MEM_AW-1:0] cnt;
  logic [MEM_AW-1:0] maskSel;
  logic [15:0] wordAddr;

  assign sclS = sclPipe[SYNC_N-1];
  assign sdaS = sdaPipe[SYNC_N-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_N-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_N-2:0], sdaIn};
      sclQ    <= sclS;
      sdaQ    <= sdaS;
    end
  end

  always_comb begin
    obs.sclRise  = sclS & ~sclQ;
    obs.sclFall  = ~sclS & sclQ;
    obs.startDet = sclS & sclQ & sdaQ & ~sdaS;
    obs.stopDet  = sclS & sclQ & ~sdaQ & sdaS;
    obs.sdaLvl   = sdaS;
    obs.bitsDone = (bitCnt == 4'd8);
    obs.rxByte   = shiftReg;
  end

  assign maskSel  = ctl.tgtReg ? REG_MASK : '1;
  assign effAddr  = cnt & maskSel;
  assign wordAddr = {addrHi, shiftReg};
  assign shiftOut = shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      addrHi   <= '0;
      cnt      <= '0;
      sdaOe    <= 1'b0;
    end else begin
      if (ctl.loadTx) begin
        shiftReg <= rdData;
        bitCnt   <= '0;
      end else if (ctl.txNext) begin
        shiftReg <= {shiftReg[6:0], 1'b0};
      end else if (ctl.shiftIn) begin
        shiftReg <= {shiftReg[6:0], sdaS};
        bitCnt   <= bitCnt + 4'd1;
      end else if (ctl.bitInc) begin
        bitCnt <= bitCnt + 4'd1;
      end else if (ctl.bitClr) begin
        bitCnt <= '0;
      end

      if (ctl.loadTx)        sdaOe <= ~rdData[7];
      else if (ctl.txNext)   sdaOe <= ~shiftReg[6];
      else if (ctl.ackDrive) sdaOe <= 1'b1;
      else if (ctl.sdaRel)   sdaOe <= 1'b0;

      if (ctl.hiLoad) addrHi <= shiftReg;

      if (ctl.cntLoad)                  cnt <= MEM_AW'(wordAddr) & maskSel;
      else if (ctl.cntInc | ctl.loadTx) cnt <= (effAddr + MEM_AW'(1)) & maskSel;
    end
  end
endmodule

// File: rtl/dts_control.sv
module dts_control
  import dts_pkg::*;
#(
  parameter int REG_AW = 6,
  parameter logic [REG_AW-1:0] STATUS_ADDR = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  obs_t              obs,
  input  logic              wrEnLatch,
  input  logic [REG_AW-1:0] regLow,
  output ctl_t              ctl
);
  phase_e state, nxt;
  logic inAck, nInAck;
  logic curTgt, nCurTgt;
  logic isRead, nRead;
  logic pendRand, nPend;
  logic lastTgt, nLast;
  logic statusWr, nStat;
  logic dataSeen, nSeen;
  logic mAck, nMAck;
  logic pfxOk, selOk, byteTgt, badRand, devAck, wrAck;

  always_comb begin
    pfxOk   = (obs.rxByte[7:4] == PFX_MEM) || (obs.rxByte[7:4] == PFX_REG);
    selOk   = (obs.rxByte[3:1] == DEV_SEL);
    byteTgt = (obs.rxByte[7:4] == PFX_REG);
    badRand = obs.rxByte[0] && pendRand && (byteTgt != lastTgt);
    devAck  = pfxOk && selOk && !badRand;
    wrAck   = wrEnLatch && !(statusWr && dataSeen);
  end

  always_comb begin
    ctl        = '0;
    ctl.tgtReg = curTgt;
    nxt     = state;
    nInAck  = inAck;
    nCurTgt = curTgt;
    nRead   = isRead;
    nPend   = pendRand;
    nLast   = lastTgt;
    nStat   = statusWr;
    nSeen   = dataSeen;
    nMAck   = mAck;
    if (obs.startDet) begin
      nxt        = ST_DEV;
      nInAck     = 1'b0;
      ctl.sdaRel = 1'b1;
      ctl.bitClr = 1'b1;
    end else if (obs.stopDet) begin
      nxt        = ST_IDLE;
      nInAck     = 1'b0;
      nPend      = 1'b0;
      ctl.sdaRel = 1'b1;
      ctl.bitClr = 1'b1;
    end else begin
      case (state)
        ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
          if (!inAck) begin
            if (obs.sclRise && !obs.bitsDone) ctl.shiftIn = 1'b1;
            if (obs.sclFall && obs.bitsDone) begin
              case (state)
                ST_DEV: begin
                  if (devAck) begin
                    ctl.ackDrive = 1'b1;
                    nInAck  = 1'b1;
                    nCurTgt = byteTgt;
                    nRead   = obs.rxByte[0];
                    if (obs.rxByte[0]) nPend = 1'b0;
                    else               nLast = byteTgt;
                  end else begin
                    nxt = ST_SKIP;
                  end
                end
                ST_AHI: begin
                  ctl.hiLoad   = 1'b1;
                  ctl.ackDrive = 1'b1;
                  nInAck       = 1'b1;
                end
                ST_ALO: begin
                  ctl.cntLoad  = 1'b1;
                  ctl.ackDrive = 1'b1;
                  nInAck       = 1'b1;
                  nPend        = 1'b1;
                end
                default: begin
                  nPend = 1'b0;
                  if (wrAck) begin
                    ctl.wrStb    = 1'b1;
                    ctl.cntInc   = 1'b1;
                    ctl.ackDrive = 1'b1;
                    nInAck       = 1'b1;
                    nSeen        = 1'b1;
                  end else begin
                    nxt = ST_SKIP;
                  end
                end
              endcase
            end
          end else if (obs.sclFall) begin
            nInAck     = 1'b0;
            ctl.bitClr = 1'b1;
            ctl.sdaRel = 1'b1;
            case (state)
              ST_DEV: begin
                if (isRead) begin
                  ctl.loadTx = 1'b1;
                  nxt        = ST_RD;
                end else begin
                  nxt = ST_AHI;
                end
              end
              ST_AHI: nxt = ST_ALO;
              ST_ALO: begin
                nxt   = ST_WR;
                nStat = curTgt && (regLow == STATUS_ADDR);
                nSeen = 1'b0;
              end
              default: nxt = ST_WR;
            endcase
          end
        end
        ST_RD: begin
          if (!inAck) begin
            if (obs.sclRise && !obs.bitsDone) ctl.bitInc = 1'b1;
            if (obs.sclFall) begin
              if (obs.bitsDone) begin
                ctl.sdaRel = 1'b1;
                nInAck     = 1'b1;
              end else begin
                ctl.txNext = 1'b1;
              end
            end
          end else begin
            if (obs.sclRise) nMAck = ~obs.sdaLvl;
            if (obs.sclFall) begin
              nInAck = 1'b0;
              if (mAck) begin
                ctl.loadTx = 1'b1;
              end else begin
                nxt        = ST_SKIP;
                ctl.sdaRel = 1'b1;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      inAck    <= 1'b0;
      curTgt   <= 1'b0;
      isRead   <= 1'b0;
      pendRand <= 1'b0;
      lastTgt  <= 1'b0;
      statusWr <= 1'b0;
      dataSeen <= 1'b0;
      mAck     <= 1'b0;
    end else begin
      state    <= nxt;
      inAck    <= nInAck;
      curTgt   <= nCurTgt;
      isRead   <= nRead;
      pendRand <= nPend;
      lastTgt  <= nLast;
      statusWr <= nStat;
      dataSeen <= nSeen;
      mAck     <= nMAck;
    end
  end
endmodule

// File: rtl/dual_target_i2c_slave.sv
module dual_target_i2c_slave
  import dts_pkg::*;
#(
  parameter int MEM_AW = 16,
  parameter int REG_AW = 6,
  parameter logic [REG_AW-1:0] STATUS_ADDR = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic              wrEnLatch,
  output logic [MEM_AW-1:0] busAddr,
  output logic              busTgt,
  output logic              busWr,
  output logic [7:0]        busWData,
  input  logic [7:0]        busRdData
);
  ctl_t ctl;
  obs_t obs;
  logic [MEM_AW-1:0] effAddr;

  dts_datapath #(.MEM_AW(MEM_AW), .REG_AW(REG_AW)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ctl(ctl), .rdData(busRdData), .obs(obs), .effAddr(effAddr),
    .shiftOut(busWData), .sdaOe(sdaOe)
  );

  dts_control #(.REG_AW(REG_AW), .STATUS_ADDR(STATUS_ADDR)) uCtl (
    .clk(clk), .rstN(rstN), .obs(obs), .wrEnLatch(wrEnLatch),
    .regLow(effAddr[REG_AW-1:0]), .ctl(ctl)
  );

  assign busAddr = effAddr;
  assign busTgt  = ctl.tgtReg;
  assign busWr   = ctl.wrStb;
endmodule

// File: rtl/dts_checker.sv
module dts_checker #(
  parameter int MEM_AW = 16,
  parameter int REG_AW = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input logic              wrEnLatch,
  input logic              busWr,
  input logic              busTgt,
  input logic [MEM_AW-1:0] busAddr
);
  localparam logic [MEM_AW-1:0] REG_SPAN = MEM_AW'(1 << REG_AW);

  // R12: enable moves only with the clock line low
  a_r12_sda_moves_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  // R5: an accepted byte is acknowledged on the next cycle
  a_r5_ack_after_write: assert property (@(posedge clk) disable iff (!rstN)
    busWr |=> sdaOe);

  // R5: write strobe lasts one cycle
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    busWr |=> !busWr);

  // R6: no strobe without the latch
  a_r6_latch_gate: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> wrEnLatch);

  // R11: register writes stay inside the register window
  a_r11_reg_window: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busTgt) |-> (busAddr < REG_SPAN));
endmodule

bind dual_target_i2c_slave dts_checker #(.MEM_AW(MEM_AW), .REG_AW(REG_AW)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe), .wrEnLatch(wrEnLatch),
  .busWr(busWr), .busTgt(busTgt), .busAddr(busAddr)
);

// File: tb/sim_dual_target_i2c_slave.sv
module sim_dual_target_i2c_slave;
  localparam int MEM_AW = 16;
  localparam int REG_AW = 6;
  localparam int HALF = 20;

  typedef struct {
    logic [15:0] a;
    logic        t;
    logic [7:0]  d;
  } wr_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic wel = 1'b1;
  logic sdaOe, busTgt, busWr;
  logic [15:0] busAddr;
  logic [7:0] busWData, busRdData;
  logic sdaBus;
  logic expOe = 1'b0;
  logic watchOn = 1'b0;
  string curReq = "R1";
  int checks = 0;
  int errors = 0;
  wr_t expQ[$];

  function automatic logic [7:0] memFn(input logic [15:0] a, input logic t);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ (t ? 8'hC3 : 8'h5A);
  endfunction

  assign sdaBus = mSda & ~sdaOe;
  assign busRdData = memFn(busAddr, busTgt);

  always #5 clk = ~clk;

  dual_target_i2c_slave #(.MEM_AW(MEM_AW), .REG_AW(REG_AW)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .wrEnLatch(wel), .busAddr(busAddr), .busTgt(busTgt), .busWr(busWr),
    .busWData(busWData), .busRdData(busRdData)
  );

  // per-clock reference of the open-drain enable while SCL is high (R8, R12)
  always @(negedge clk) begin
    if (rstN && watchOn && scl) begin
      checks++;
      if (sdaOe !== expOe) begin
        errors++;
        $display("FAIL %s/R12 sdaOe got %0b exp %0b at %0t", curReq, sdaOe, expOe, $time);
      end
    end
  end

  // write strobes against expected queue (R5 R6 R7)
  always @(negedge clk) begin
    wr_t e;
    if (rstN && busWr) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL %s unexpected write got a=%h t=%0b d=%h exp none", curReq, busAddr, busTgt, busWData);
      end else begin
        e = expQ.pop_front();
        if (busAddr !== e.a || busTgt !== e.t || busWData !== e.d) begin
          errors++;
          $display("FAIL %s write got a=%h t=%0b d=%h exp a=%h t=%0b d=%h",
                   curReq, busAddr, busTgt, busWData, e.a, e.t, e.d);
        end
      end
    end
  end

  task automatic hold(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic pushWr(input logic [15:0] a, input logic t, input logic [7:0] d);
    wr_t e;
    e.a = a; e.t = t; e.d = d;
    expQ.push_back(e);
  endtask

  task automatic startC();
    curReq = "R2";
    mSda = 1'b1; hold(HALF);
    expOe = 1'b0; scl = 1'b1; hold(HALF);
    mSda = 1'b0; hold(HALF);
    scl = 1'b0; hold(3);
  endtask

  task automatic stopC();
    curReq = "R2";
    mSda = 1'b0; hold(HALF);
    expOe = 1'b0; scl = 1'b1; hold(HALF);
    mSda = 1'b1; hold(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expAck, input string req);
    logic gotAck;
    curReq = req;
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; hold(HALF);
      expOe = 1'b0; scl = 1'b1; hold(HALF);
      scl = 1'b0; hold(3);
    end
    mSda = 1'b1; hold(HALF);
    expOe = expAck; scl = 1'b1; hold(HALF / 2);
    gotAck = (sdaBus == 1'b0);
    chk({req, " ack"}, {31'd0, gotAck}, {31'd0, expAck});
    hold(HALF / 2);
    scl = 1'b0; hold(3);
    expOe = 1'b0;
  endtask

  task automatic recvByte(input logic [7:0] exp, input logic mAckB, input string req);
    logic [7:0] got;
    curReq = req;
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(HALF);
      expOe = ~exp[i]; scl = 1'b1; hold(HALF / 2);
      got[i] = sdaBus; hold(HALF / 2);
      scl = 1'b0; hold(3);
    end
    chk({req, " data"}, {24'd0, got}, {24'd0, exp});
    mSda = mAckB ? 1'b0 : 1'b1; hold(HALF);
    expOe = 1'b0; scl = 1'b1; hold(HALF);
    scl = 1'b0; hold(3);
    mSda = 1'b1;
  endtask

  initial begin
    hold(10);
    // R1: reset state
    chk("R1 sdaOe", {31'd0, sdaOe}, 32'd0);
    chk("R1 busWr", {31'd0, busWr}, 32'd0);
    rstN = 1'b1;
    hold(5);
    chk("R1 busAddr", {16'd0, busAddr}, 32'd0);
    watchOn = 1'b1;

    // R9: current-address read from reset starts at 0
    startC();
    sendByte(8'hAF, 1'b1, "R3");
    recvByte(memFn(16'h0000, 1'b0), 1'b1, "R9");
    recvByte(memFn(16'h0001, 1'b0), 1'b0, "R8");
    stopC();

    // R4 R5: memory write, three bytes
    pushWr(16'h1234, 1'b0, 8'h11);
    pushWr(16'h1235, 1'b0, 8'h22);
    pushWr(16'h1236, 1'b0, 8'hE3);
    startC();
    sendByte(8'hAE, 1'b1, "R3");
    sendByte(8'h12, 1'b1, "R4");
    sendByte(8'h34, 1'b1, "R4");
    sendByte(8'h11, 1'b1, "R5");
    sendByte(8'h22, 1'b1, "R5");
    sendByte(8'hE3, 1'b1, "R5");
    stopC();
    chk("R5 queue drained", expQ.size(), 32'd0);

    // R9: current-address read continues from the counter
    startC();
    sendByte(8'hAF, 1'b1, "R3");
    recvByte(memFn(16'h1237, 1'b0), 1'b0, "R9");
    stopC();

    // R3: select mismatch and prefix mismatch stay silent
    startC();
    sendByte(8'hA8, 1'b0, "R3");
    sendByte(8'h00, 1'b0, "R3");
    sendByte(8'h55, 1'b0, "R3");
    stopC();
    startC();
    sendByte(8'hBE, 1'b0, "R3");
    sendByte(8'h01, 1'b0, "R3");
    stopC();

    // R3 R4: register target write
    pushWr(16'h0005, 1'b1, 8'hA5);
    startC();
    sendByte(8'hDE, 1'b1, "R3");
    sendByte(8'h00, 1'b1, "R4");
    sendByte(8'h05, 1'b1, "R4");
    sendByte(8'hA5, 1'b1, "R5");
    stopC();

    // R6: latch low refuses data
    wel = 1'b0;
    startC();
    sendByte(8'hAE, 1'b1, "R3");
    sendByte(8'h00, 1'b1, "R4");
    sendByte(8'h10, 1'b1, "R4");
    sendByte(8'h77, 1'b0, "R6");
    sendByte(8'h88, 1'b0, "R6");
    stopC();
    wel = 1'b1;

    // R10: random read switching target is refused
    startC();
    sendByte(8'hAE, 1'b1, "R3");
    sendByte(8'h00, 1'b1, "R4");
    sendByte(8'h20, 1'b1, "R4");
    startC();
    sendByte(8'hDF, 1'b0, "R10");
    stopC();

    // R10 R11 R4: random register read with masked address, wraps at 2^REG_AW
    startC();
    sendByte(8'hDE, 1'b1, "R3");
    sendByte(8'h12, 1'b1, "R4");
    sendByte(8'hFE, 1'b1, "R4");
    startC();
    sendByte(8'hDF, 1'b1, "R10");
    recvByte(memFn(16'h003E, 1'b1), 1'b1, "R10");
    recvByte(memFn(16'h003F, 1'b1), 1'b1, "R11");
    recvByte(memFn(16'h0000, 1'b1), 1'b0, "R11");
    stopC();

    // R11: memory wraps at 2^MEM_AW
    startC();
    sendByte(8'hAE, 1'b1, "R3");
    sendByte(8'hFF, 1'b1, "R4");
    sendByte(8'hFF, 1'b1, "R4");
    startC();
    sendByte(8'hAF, 1'b1, "R10");
    recvByte(memFn(16'hFFFF, 1'b0), 1'b1, "R11");
    recvByte(memFn(16'h0000, 1'b0), 1'b0, "R11");
    stopC();

    // R7: status register takes one byte only
    pushWr(16'h003F, 1'b1, 8'h02);
    startC();
    sendByte(8'hDE, 1'b1, "R3");
    sendByte(8'h00, 1'b1, "R4");
    sendByte(8'h3F, 1'b1, "R4");
    sendByte(8'h02, 1'b1, "R7");
    sendByte(8'h06, 1'b0, "R7");
    stopC();
    chk("R7 queue drained", expQ.size(), 32'd0);

    // R2: after a stop a byte without start is ignored
    scl = 1'b0; hold(HALF);
    sendByte(8'hAE, 1'b0, "R2");
    sendByte(8'h00, 1'b0, "R2");
    stopC();

    hold(20);
    chk("R5 no pending writes", expQ.size(), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 got hang exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule